// File: doc/BRIEF.md
# Prioritised Transmit Buffer Manager

This block keeps track of a small pool of transmit message buffers inside a CAN FD controller. Each buffer moves through its own life cycle (empty, ready, sent, failed, aborted). Software changes those states with masked commands, and the block reports all of them at once in a packed status word. The buffer contents, frame serialisation and bus arbitration are handled elsewhere. This block only decides which buffer goes next and records how each attempt ended.

Whenever the block is idle and enabled, a priority arbiter looks at the ready buffers. It launches the best one towards the transmitter through a request/done port. The launched buffer is protected from commands until the transmitter answers. The outcome is then written back, a frame counter advances on success, and one-cycle interrupt request pulses are raised. Selection runs again after every completion until no eligible buffer is left.

Top module: `txbm_top`

## Requirements
- R1: The status word holds buffer i's state in bits 4i+3:4i, coded as empty = 0, ready = 1, sent-ok = 2, failed = 3, aborted = 4.
- R2: After reset every buffer is empty, `idle` is 1, `tx_busy` and `tx_req` are 0, the frame counter is 0 and `not_full` is 1.
- R3: The abort operation changes a ready buffer to aborted and leaves a buffer in any other state as it was.
- R4: The make-ready operation changes a buffer to ready from empty, sent-ok, failed or aborted.
- R5: The make-empty operation changes a buffer to empty from sent-ok, failed or aborted, and leaves a ready buffer ready.
- R6: A command acts only on buffers whose bit is set in `cmd_sel`, and only while `ctrl_en` is 1. When one command carries several operations, they apply in the order abort, then make-ready, then make-empty.
- R7: The priority of buffer i is `prio_word` bits 4i+2:4i. The launched buffer is the ready buffer with the strictly greatest priority, so a tie goes to the lowest index and priority 0 is never launched. Nothing is launched while `ctrl_en` is 0.
- R8: When `tx_done` arrives with `tx_ok` = 1, the buffer becomes sent-ok and the frame counter increments. `irq_tx_done` and `irq_buf_chg` each pulse high for exactly one cycle.
- R9: When `tx_done` arrives with `tx_ok` = 0, the buffer becomes failed, only `irq_buf_chg` pulses, and the frame counter holds its value.
- R10: While a transmission is in flight, commands do not change the launched buffer, `tx_busy` is 1 and `idle` is 0.
- R11: After a completion the next eligible ready buffer is launched one clock edge later. This repeats until none remains.
- R12: `not_full` is 1 exactly when at least one buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; gates commands and launches |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_sel | input | NUM_BUF | Buffer select mask |
| cmd_abort | input | 1 | Abort operation |
| cmd_ready | input | 1 | Make-ready operation |
| cmd_empty | input | 1 | Make-empty operation |
| prio_word | input | 4*NUM_BUF | Packed 3-bit priorities on a 4-bit pitch |
| tx_done | input | 1 | Transmitter finished the current frame |
| tx_ok | input | 1 | Outcome qualifier for `tx_done` |
| tx_req | output | 1 | A buffer is handed to the transmitter |
| tx_idx | output | IDX_W | Index of the handed buffer |
| status_word | output | 4*NUM_BUF | Packed buffer states |
| not_full | output | 1 | At least one buffer empty |
| tx_busy | output | 1 | Transmission in flight |
| idle | output | 1 | No transmission in flight |
| frame_cnt | output | CNT_W | Successful frame count |
| irq_tx_done | output | 1 | Success interrupt request pulse |
| irq_buf_chg | output | 1 | Buffer-state-changed interrupt request pulse |

## Verification
A command sampled at clock edge E shows up in `status_word` and `not_full` right after E. The launch it makes possible shows up on `tx_req`/`tx_idx` right after E+1. A `tx_done` sampled at edge D updates the state, the counter and both interrupt pulses right after D. The pulses drop and the next launch appears right after D+1. The bench drives every input just after a falling edge and reads outputs at the following falling edge, so each check sits exactly one rising edge after its stimulus. Checks that expect no effect are read at that same point, before any further stimulus.

// File: rtl/txbm_pkg.sv
// Package: shared state encoding and command next-state function for the
// transmit buffer manager. Assumes one 4-bit field per buffer.
package txbm_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        BS_EMPTY   = 4'd0,
        BS_READY   = 4'd1,
        BS_TXOK    = 4'd2,
        BS_FAILED  = 4'd3,
        BS_ABORTED = 4'd4
    } buf_state_e;

    // Apply abort, make-ready, make-empty in that fixed order to one state.
    function automatic buf_state_e apply_ops(
        input buf_state_e cur,
        input logic       op_abort,
        input logic       op_ready,
        input logic       op_empty
    );
        buf_state_e s;
        s = cur;
        if (op_abort && s == BS_READY) begin
            s = BS_ABORTED;
        end
        if (op_ready && (s == BS_EMPTY || s == BS_TXOK ||
                         s == BS_FAILED || s == BS_ABORTED)) begin
            s = BS_READY;
        end
        if (op_empty && (s == BS_TXOK || s == BS_FAILED ||
                         s == BS_ABORTED)) begin
            s = BS_EMPTY;
        end
        return s;
    endfunction

endpackage

// File: rtl/txbm_slot.sv
// Module: state holder for one transmit buffer.
// Applies a masked software command when cmd_hit is set, and writes the
// transmission outcome when fin_hit is set. The two never coincide because
// the scheduler freezes the in-flight buffer against commands.
module txbm_slot
    import txbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_hit,
    input  logic               op_abort,
    input  logic               op_ready,
    input  logic               op_empty,
    input  logic               fin_hit,
    input  logic               fin_ok,
    output logic [STATE_W-1:0] state_o
);

    buf_state_e state_q;
    buf_state_e state_d;

    // Next-state selection: outcome first, then command, else hold.
    always_comb begin
        state_d = state_q;
        if (fin_hit) begin
            state_d = fin_ok ? BS_TXOK : BS_FAILED;
        end else if (cmd_hit) begin
            state_d = apply_ops(state_q, op_abort, op_ready, op_empty);
        end
    end

    // State register with synchronous active-low reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R3: a lone abort on a non-ready buffer changes nothing.
    p_abort_nonready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !fin_hit && op_abort && !op_ready && !op_empty &&
         state_q != BS_READY) |=> $stable(state_q));

    // R5: a lone make-empty never takes a buffer out of ready.
    p_empty_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !fin_hit && op_empty && !op_ready && !op_abort &&
         state_q == BS_READY) |=> state_q == BS_READY);

    // R8 / R9: an outcome lands as sent-ok or failed.
    p_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_hit && fin_ok) |=> state_q == BS_TXOK);
    p_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_hit && !fin_ok) |=> state_q == BS_FAILED);

endmodule

// File: rtl/txbm_arbiter.sv
// Module: combinational priority selector over the ready buffers.
// Picks the ready buffer with the strictly greatest nonzero priority, with
// ties going to the lowest index. Clock and reset serve only its checks.
module txbm_arbiter
    import txbm_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int WORD_W = STATE_W * NUM_BUF
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] status_word,
    input  logic [WORD_W-1:0] prio_word,
    output logic              win_found,
    output logic [IDX_W-1:0]  win_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Scan from index 0 upward; only a strictly greater priority replaces.
    always_comb begin
        best_prio = '0;
        win_found = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (status_word[i*STATE_W +: STATE_W] == BS_READY &&
                prio_word[i*STATE_W +: PRIO_W] > best_prio) begin
                best_prio = prio_word[i*STATE_W +: PRIO_W];
                win_idx   = IDX_W'(i);
                win_found = 1'b1;
            end
        end
    end

    // R7: a winner is always ready and never carries priority zero.
    p_winner_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> (status_word[win_idx*STATE_W +: STATE_W] == BS_READY));
    p_winner_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> (prio_word[win_idx*STATE_W +: PRIO_W] != '0));

endmodule

// File: rtl/txbm_sched.sv
// Module: launch/complete scheduler with the frame counter and interrupt
// pulses. It holds the in-flight buffer index, produces the freeze mask
// that shields that buffer from commands, and produces the per-buffer
// outcome strobes. Assumes tx_done is ignored while nothing is in flight.
module txbm_sched
    import txbm_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int WORD_W = STATE_W * NUM_BUF
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               win_found,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic               tx_done,
    input  logic               tx_ok,
    input  logic [WORD_W-1:0]  status_word,
    output logic               busy,
    output logic [IDX_W-1:0]   cur_idx,
    output logic [NUM_BUF-1:0] freeze_mask,
    output logic [NUM_BUF-1:0] fin_mask,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic               irq_tx_done,
    output logic               irq_buf_chg
);

    logic launch;
    logic finish;

    assign launch = !busy && ctrl_en && win_found;
    assign finish = busy && tx_done;

    // Per-buffer freeze and outcome strobes.
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_mask
        assign freeze_mask[g] = (busy && cur_idx == IDX_W'(g)) ||
                                (launch && win_idx == IDX_W'(g));
        assign fin_mask[g]    = finish && cur_idx == IDX_W'(g);
    end

    // In-flight flag and latched buffer index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_idx <= '0;
        end else if (finish) begin
            busy    <= 1'b0;
        end else if (launch) begin
            busy    <= 1'b1;
            cur_idx <= win_idx;
        end
    end

    // Successful frame counter, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (finish && tx_ok) begin
            frame_cnt <= frame_cnt + CNT_W'(1);
        end
    end

    // One-cycle interrupt request pulses after a completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx_done <= 1'b0;
            irq_buf_chg <= 1'b0;
        end else begin
            irq_tx_done <= finish && tx_ok;
            irq_buf_chg <= finish;
        end
    end

    // R8: a success bumps the counter by exactly one.
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done && tx_ok) |=> frame_cnt == $past(frame_cnt) + CNT_W'(1));

    // R9: a failure leaves the counter alone and raises no success pulse.
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done && !tx_ok) |=> ($stable(frame_cnt) && !irq_tx_done));

    // R10: the in-flight buffer state does not move until completion.
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_done) |=>
            $stable(status_word[cur_idx*STATE_W +: STATE_W]));

    // R7: no launch while disabled.
    p_no_launch_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_en) |=> !busy);

    // R11: a completion always frees the scheduler for one cycle.
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done) |=> !busy);

endmodule

// File: rtl/txbm_top.sv
// Module: prioritised transmit buffer manager top level.
// Wires NUM_BUF buffer slots, the priority arbiter and the scheduler, and
// derives the not-full flag. Assumes cmd_valid is a single-cycle strobe.
module txbm_top
    import txbm_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int PRIO_W  = 3,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int WORD_W = STATE_W * NUM_BUF
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic               cmd_valid,
    input  logic [NUM_BUF-1:0] cmd_sel,
    input  logic               cmd_abort,
    input  logic               cmd_ready,
    input  logic               cmd_empty,
    input  logic [WORD_W-1:0]  prio_word,
    input  logic               tx_done,
    input  logic               tx_ok,
    output logic               tx_req,
    output logic [IDX_W-1:0]   tx_idx,
    output logic [WORD_W-1:0]  status_word,
    output logic               not_full,
    output logic               tx_busy,
    output logic               idle,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic               irq_tx_done,
    output logic               irq_buf_chg
);

    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic               busy;
    logic [IDX_W-1:0]   cur_idx;
    logic [NUM_BUF-1:0] freeze_mask;
    logic [NUM_BUF-1:0] fin_mask;
    logic [NUM_BUF-1:0] empty_vec;

    // One slot per buffer; commands masked by select, enable and freeze.
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        logic hit;
        assign hit = cmd_valid && ctrl_en && cmd_sel[g] && !freeze_mask[g];

        txbm_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_hit  (hit),
            .op_abort (cmd_abort),
            .op_ready (cmd_ready),
            .op_empty (cmd_empty),
            .fin_hit  (fin_mask[g]),
            .fin_ok   (tx_ok),
            .state_o  (status_word[g*STATE_W +: STATE_W])
        );

        assign empty_vec[g] = (status_word[g*STATE_W +: STATE_W] == BS_EMPTY);
    end

    txbm_arbiter #(
        .NUM_BUF (NUM_BUF),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_word (status_word),
        .prio_word   (prio_word),
        .win_found   (win_found),
        .win_idx     (win_idx)
    );

    txbm_sched #(
        .NUM_BUF (NUM_BUF),
        .CNT_W   (CNT_W)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_en     (ctrl_en),
        .win_found   (win_found),
        .win_idx     (win_idx),
        .tx_done     (tx_done),
        .tx_ok       (tx_ok),
        .status_word (status_word),
        .busy        (busy),
        .cur_idx     (cur_idx),
        .freeze_mask (freeze_mask),
        .fin_mask    (fin_mask),
        .frame_cnt   (frame_cnt),
        .irq_tx_done (irq_tx_done),
        .irq_buf_chg (irq_buf_chg)
    );

    assign not_full = |empty_vec;
    assign tx_req   = busy;
    assign tx_idx   = cur_idx;
    assign tx_busy  = busy;
    assign idle     = !busy;

    // R8: the success pulse never comes without the buffer-change pulse.
    p_irq_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_done |-> irq_buf_chg);

    // R8: each interrupt pulse lasts one cycle, since a completion
    // always frees the scheduler for a cycle.
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_buf_chg |=> !irq_buf_chg);

endmodule

// File: tb/test_txbm_top.sv
// Directed bench for txbm_top: inputs are driven after a falling edge and
// outputs are read at the next falling edge.
module test_txbm_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NB = 4;
    localparam int  WW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctrl_en;
    logic          cmd_valid;
    logic [NB-1:0] cmd_sel;
    logic          cmd_abort, cmd_ready, cmd_empty;
    logic [WW-1:0] prio_word;
    logic          tx_done, tx_ok;
    logic          tx_req;
    logic [1:0]    tx_idx;
    logic [WW-1:0] status_word;
    logic          not_full, tx_busy, idle;
    logic [15:0]   frame_cnt;
    logic          irq_tx_done, irq_buf_chg;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txbm_top i_txbm_top (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_valid(cmd_valid),
        .cmd_sel(cmd_sel), .cmd_abort(cmd_abort), .cmd_ready(cmd_ready),
        .cmd_empty(cmd_empty), .prio_word(prio_word), .tx_done(tx_done),
        .tx_ok(tx_ok), .tx_req(tx_req), .tx_idx(tx_idx),
        .status_word(status_word), .not_full(not_full), .tx_busy(tx_busy),
        .idle(idle), .frame_cnt(frame_cnt), .irq_tx_done(irq_tx_done),
        .irq_buf_chg(irq_buf_chg)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Issue one command strobe; returns at the first falling edge after it.
    task automatic issue(input logic [NB-1:0] sel, input logic ab,
                         input logic rd, input logic em);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_sel = sel;
        cmd_abort = ab; cmd_ready = rd; cmd_empty = em;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_sel = '0;
        cmd_abort = 1'b0; cmd_ready = 1'b0; cmd_empty = 1'b0;
    endtask

    // Report one transmitter completion.
    task automatic finish_tx(input logic ok);
        @(negedge clk);
        tx_done = 1'b1; tx_ok = ok;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0;
    endtask

    task automatic t_reset;
        check("R2", "status", 32'(status_word), 32'h0000);
        check("R2", "idle", 32'(idle), 1);
        check("R2", "busy", 32'(tx_busy), 0);
        check("R2", "req", 32'(tx_req), 0);
        check("R2", "count", 32'(frame_cnt), 0);
        check("R12", "not_full at reset", 32'(not_full), 1);
    endtask

    task automatic t_commands;
        issue(4'b0011, 0, 1, 0);
        check("R4", "ready from empty", 32'(status_word), 32'h0011);
        check("R1", "field of buffer1", 32'(status_word[7:4]), 1);
        issue(4'b0001, 1, 0, 0);
        check("R3", "abort ready", 32'(status_word), 32'h0014);
        issue(4'b0100, 1, 0, 0);
        check("R3", "abort empty ignored", 32'(status_word), 32'h0014);
        issue(4'b0010, 0, 0, 1);
        check("R5", "empty on ready ignored", 32'(status_word), 32'h0014);
        issue(4'b0001, 0, 0, 1);
        check("R5", "empty from aborted", 32'(status_word), 32'h0010);
        issue(4'b0100, 0, 1, 0);
        check("R6", "select bits only", 32'(status_word), 32'h0110);
        ctrl_en = 1'b0;
        issue(4'b1000, 0, 1, 0);
        check("R6", "disabled ignored", 32'(status_word), 32'h0110);
        ctrl_en = 1'b1;
        issue(4'b0100, 1, 1, 0);
        check("R6", "abort then ready", 32'(status_word), 32'h0110);
        issue(4'b0010, 1, 0, 1);
        check("R6", "abort then empty", 32'(status_word), 32'h0100);
        check("R12", "some empty", 32'(not_full), 1);
        issue(4'b1111, 0, 1, 0);
        check("R4", "all ready", 32'(status_word), 32'h1111);
        check("R12", "none empty", 32'(not_full), 0);
        check("R7", "prio zero not launched", 32'(tx_req), 0);
    endtask

    task automatic t_schedule;
        @(negedge clk);
        prio_word = 16'h0553;
        @(negedge clk);
        check("R7", "launch", 32'(tx_req), 1);
        check("R7", "tie to lower index", 32'(tx_idx), 1);
        check("R10", "busy", 32'(tx_busy), 1);
        check("R10", "not idle", 32'(idle), 0);
        issue(4'b1010, 1, 0, 0);
        check("R10", "in-flight frozen, other aborted", 32'(status_word), 32'h4111);
        finish_tx(1'b1);
        check("R8", "sent ok", 32'(status_word), 32'h4121);
        check("R8", "count", 32'(frame_cnt), 1);
        check("R8", "irq done", 32'(irq_tx_done), 1);
        check("R8", "irq chg", 32'(irq_buf_chg), 1);
        check("R11", "released", 32'(tx_req), 0);
        @(negedge clk);
        check("R8", "irq pulse ends", 32'(irq_buf_chg), 0);
        check("R11", "relaunch", 32'(tx_req), 1);
        check("R11", "next index", 32'(tx_idx), 2);
        finish_tx(1'b0);
        check("R9", "failed", 32'(status_word), 32'h4321);
        check("R9", "count held", 32'(frame_cnt), 1);
        check("R9", "no done irq", 32'(irq_tx_done), 0);
        check("R9", "chg irq", 32'(irq_buf_chg), 1);
        @(negedge clk);
        check("R11", "third launch idx", 32'(tx_idx), 0);
        check("R11", "third launch req", 32'(tx_req), 1);
        finish_tx(1'b1);
        check("R8", "count 2", 32'(frame_cnt), 2);
        @(negedge clk);
        check("R11", "nothing left", 32'(tx_req), 0);
        check("R11", "idle again", 32'(idle), 1);
        issue(4'b1000, 0, 1, 0);
        @(negedge clk);
        check("R7", "prio 0 ready stays", 32'(tx_req), 0);
        check("R7", "status", 32'(status_word), 32'h1322);
        ctrl_en = 1'b0;
        prio_word = 16'h7553;
        repeat (3) @(negedge clk);
        check("R7", "no launch when disabled", 32'(tx_req), 0);
        ctrl_en = 1'b1;
        @(negedge clk);
        check("R7", "launch after enable", 32'(tx_idx), 3);
        check("R7", "launch req", 32'(tx_req), 1);
        finish_tx(1'b1);
        check("R8", "count 3", 32'(frame_cnt), 3);
        issue(4'b0001, 0, 0, 1);
        check("R5", "empty from sent", 32'(status_word), 32'h2320);
        check("R12", "empty again", 32'(not_full), 1);
    endtask

    initial begin
        rst_n = 1'b0; ctrl_en = 1'b1; cmd_valid = 1'b0; cmd_sel = '0;
        cmd_abort = 1'b0; cmd_ready = 1'b0; cmd_empty = 1'b0;
        prio_word = '0; tx_done = 1'b0; tx_ok = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_commands();
        t_schedule();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule